// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns one active-low, asynchronous interrupt pin into a latched interrupt request for a CPU. The pin is brought into the clock domain through a synchronizer. Its falling edge is then detected on the synchronized level. A small control/status register selects the trigger style and masks the request. The same register exposes a pending flag that software can poll and takes a write-one acknowledge. Two trigger styles exist. In edge style, a falling edge arms the latch and any clear takes effect at once. In level style, the latch also holds for as long as the pin stays low.

Clears come from two sources: a software acknowledge and the CPU's vector-fetch strobe. A system integration block supplies a break-state flag and a break-clear enable. While the break state is active, these decide whether a software acknowledge may touch the latch. The synchronized pin level is exported so that branch-on-pin instructions can read it. The service routine address is also exported as a constant vector. All pins are plain control and status signals. No stream interface exists, so there is no back-pressure.

Top module: `extirq_ctrl`

## Requirements
- R1: `pin_level` equals the value that `pin_n` had two rising clock edges earlier, through a two-flop synchronizer that resets to 1.
- R2: With the trigger bit (register bit 0) at 0, a falling edge of the synchronized pin sets the pending latch on the next edge. A low level alone never sets it.
- R3: With the trigger bit at 0, an acknowledge write (bit 2 written as 1) or a `vec_fetch` pulse clears the pending latch on that edge, even if the pin is still low.
- R4: With the trigger bit at 1, a clear request that arrives while the synchronized pin is low is remembered. The latch stays set and clears on the first edge at which the synchronized pin is seen high.
- R5: With the trigger bit at 1, if the synchronized pin is already high when the clear request arrives, the latch clears on that edge.
- R6: A falling edge at the same edge as any clear request sets the latch. The set wins over the clear in both trigger styles.
- R7: Reset clears the pending latch, the trigger bit and the mask bit, even while the pin is held low.
- R8: The pending flag (read bit 3) shows the latch whatever the mask is. `irq_req` is high exactly when the latch is set and the mask bit (bit 1) is 0. `vec_addr` is 0xFFFA.
- R9: While `brk_active` is 1 and `brk_clr_en` is 0, an acknowledge write leaves the latch unchanged.
- R10: While `brk_active` is 1 and `brk_clr_en` is 1, an acknowledge write clears the latch. The latch stays clear after the break state ends.
- R11: `vec_fetch` clears the latch whatever the break inputs are.
- R12: Reads return {pending, 0, mask, trigger} in bits 3..0. The acknowledge bit always reads 0, and writes to bit 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data: bit0 trigger, bit1 mask, bit2 acknowledge, bit3 ignored |
| reg_rdata | output | 4 | Read data: bit0 trigger, bit1 mask, bit2 zero, bit3 pending |
| vec_fetch | input | 1 | CPU vector-fetch strobe for this source |
| brk_active | input | 1 | Break state is active |
| brk_clr_en | input | 1 | Allow software acknowledge during break |
| irq_req | output | 1 | Masked interrupt request |
| pin_level | output | 1 | Synchronized pin level |
| vec_addr | output | 16 | Service vector address |

## Verification
Every internal state bit of the block can be seen at the ports. A wrong pending latch shows in `reg_rdata[3]` one edge after the event that mis-set or mis-cleared it, and in `irq_req` at the same time unless the mask hides it. A lost remembered acknowledge in level style shows on the first edge at which the synchronized pin is high: the pending flag stays set when it should drop. A synchronizer with the wrong depth shifts `pin_level`, and the moment the latch sets, by one cycle. That shift is caught on the first pin transition.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W    = 4;
  localparam int BIT_TRIG = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_PEND = 3;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= pin_async;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_sync;
  end

  assign pin_sync   = chain[STAGES-1];
  assign fall_pulse = prev_q & ~pin_sync;

  // Warm-up counter so the delay check never looks before reset release.
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk
    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (pin_sync == $past(pin_async, 2)));
  end
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             vec_fetch,
  input  logic             brk_active,
  input  logic             brk_clr_en,
  input  logic             pend,
  output trig_e            trig,
  output logic             mask,
  output logic             clr_req,
  output logic [REG_W-1:0] rdata
);
  logic ack_wr;
  logic ack_allowed;
  logic unused_pend_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= TRIG_EDGE;
      mask <= 1'b0;
    end else if (wr) begin
      trig <= trig_e'(wdata[BIT_TRIG]);
      mask <= wdata[BIT_MASK];
    end
  end

  assign unused_pend_wr = wdata[BIT_PEND];
  assign ack_wr         = wr & wdata[BIT_ACK];
  assign ack_allowed    = ~brk_active | brk_clr_en;
  assign clr_req        = (ack_wr & ack_allowed) | vec_fetch;

  always_comb begin
    rdata           = '0;
    rdata[BIT_TRIG] = trig;
    rdata[BIT_MASK] = mask;
    rdata[BIT_ACK]  = 1'b0;
    rdata[BIT_PEND] = pend;
  end

  assert_brk_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !brk_clr_en && !vec_fetch) |-> !clr_req);
  assert_fetch_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> clr_req);
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
  import extirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  fall,
  input  logic  pin_high,
  input  logic  clr_req,
  output logic  pend
);
  logic held_q;
  logic pend_d, held_d;

  always_comb begin
    pend_d = pend;
    held_d = held_q;
    if (fall) begin
      pend_d = 1'b1;
      held_d = 1'b0;
    end else if (trig == TRIG_EDGE) begin
      held_d = 1'b0;
      if (clr_req) pend_d = 1'b0;
    end else if (!pend) begin
      held_d = 1'b0;
    end else if (clr_req || held_q) begin
      if (pin_high) begin
        pend_d = 1'b0;
        held_d = 1'b0;
      end else begin
        held_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      held_q <= 1'b0;
    end else begin
      pend   <= pend_d;
      held_q <= held_d;
    end
  end

  assert_fall_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pend);
  assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_EDGE && clr_req && !fall) |=> !pend);
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == TRIG_LEVEL && pend && !pin_high) |=> pend);
  assert_no_spont_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !fall) |=> !pend);
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_BASE    = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              vec_fetch,
  input  logic              brk_active,
  input  logic              brk_clr_en,
  output logic              irq_req,
  output logic              pin_level,
  output logic [ADDR_W-1:0] vec_addr
);
  logic  fall;
  logic  pend;
  logic  mask;
  logic  clr_req;
  trig_e trig;

  extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_n),
    .pin_sync(pin_level), .fall_pulse(fall)
  );

  extirq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .vec_fetch(vec_fetch), .brk_active(brk_active), .brk_clr_en(brk_clr_en),
    .pend(pend), .trig(trig), .mask(mask), .clr_req(clr_req), .rdata(reg_rdata)
  );

  extirq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .trig(trig), .fall(fall),
    .pin_high(pin_level), .clr_req(clr_req), .pend(pend)
  );

  assign irq_req  = pend & ~mask;
  assign vec_addr = ADDR_W'(VEC_BASE);

  assert_req_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> reg_rdata[BIT_PEND]);
  assert_ack_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[BIT_ACK]);
endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       vec_fetch = 1'b0;
  logic       brk_active = 1'b0;
  logic       brk_clr_en = 1'b0;
  logic       irq_req;
  logic       pin_level;
  logic [15:0] vec_addr;

  int compared = 0;
  int mismatched = 0;
  string phase = "R7";

  always #(CLK_PERIOD/2) clk = ~clk;

  extirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_fetch(vec_fetch),
    .brk_active(brk_active), .brk_clr_en(brk_clr_en), .irq_req(irq_req),
    .pin_level(pin_level), .vec_addr(vec_addr)
  );

  // Behavioural reference model
  bit seen_q[$] = '{1'b1, 1'b1};
  bit m_prev = 1'b1;
  bit m_pend = 1'b0;
  bit m_wait = 1'b0;
  bit m_trig = 1'b0;
  bit m_mask = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q = '{1'b1, 1'b1};
      m_prev = 1'b1; m_pend = 1'b0; m_wait = 1'b0;
      m_trig = 1'b0; m_mask = 1'b0;
    end else begin
      bit lvl, edge_now, clr;
      lvl = seen_q[0];
      edge_now = m_prev && !lvl;
      clr = vec_fetch || (reg_wr && reg_wdata[2] && (!brk_active || brk_clr_en));
      if (edge_now) begin
        m_pend = 1'b1; m_wait = 1'b0;
      end else if (!m_trig) begin
        m_wait = 1'b0;
        if (clr) m_pend = 1'b0;
      end else if (m_pend && (clr || m_wait)) begin
        if (lvl) begin m_pend = 1'b0; m_wait = 1'b0; end
        else m_wait = 1'b1;
      end else if (!m_pend) begin
        m_wait = 1'b0;
      end
      if (reg_wr) begin
        m_trig = reg_wdata[0];
        m_mask = reg_wdata[1];
      end
      m_prev = lvl;
      void'(seen_q.pop_front());
      seen_q.push_back(pin_n);
    end
  end

  task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("pin_level", 16'(pin_level), 16'(seen_q[0]));
    cmp("reg_rdata", 16'(reg_rdata), 16'({m_pend, 1'b0, m_mask, m_trig}));
    cmp("irq_req", 16'(irq_req), 16'(m_pend && !m_mask));
    cmp("vec_addr R8", vec_addr, 16'hFFFA);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wreg(input logic [3:0] d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 4'h0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); #1;
    pin_n = v;
  endtask

  task automatic fetch;
    @(negedge clk); #1;
    vec_fetch = 1'b1;
    @(negedge clk); #1;
    vec_fetch = 1'b0;
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        while (wd < 20000) begin @(posedge clk); wd++; end
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none

    phase = "R7"; tick(3);
    @(negedge clk); #1; rst_n = 1'b1;
    tick(2);

    phase = "R1";
    set_pin(1'b0); set_pin(1'b1); tick(4);

    phase = "R2";
    set_pin(1'b0); tick(6);
    phase = "R3";
    wreg(4'b0100); tick(3);
    set_pin(1'b1); tick(3); set_pin(1'b0); tick(5);
    fetch(); tick(3);

    phase = "R8";
    set_pin(1'b1); tick(3);
    wreg(4'b0010); set_pin(1'b0); tick(5);
    wreg(4'b0000); tick(2);
    phase = "R12";
    wreg(4'b1000); tick(2);
    wreg(4'b0100); tick(2);
    wreg(4'b1011); tick(2);
    wreg(4'b0000); tick(2);

    phase = "R4";
    set_pin(1'b1); tick(3);
    wreg(4'b0001); set_pin(1'b0); tick(5);
    wreg(4'b0101); tick(5);
    set_pin(1'b1); tick(5);
    phase = "R5";
    set_pin(1'b0); tick(5); set_pin(1'b1); tick(5);
    wreg(4'b0101); tick(3);

    phase = "R6";
    @(negedge clk); #1; vec_fetch = 1'b1;
    set_pin(1'b0); tick(4);
    @(negedge clk); #1; vec_fetch = 1'b0;
    set_pin(1'b1); tick(4);
    wreg(4'b0000);
    @(negedge clk); #1; vec_fetch = 1'b1;
    set_pin(1'b0); tick(4);
    @(negedge clk); #1; vec_fetch = 1'b0;
    set_pin(1'b1); tick(4);

    phase = "R9";
    set_pin(1'b0); tick(5);
    @(negedge clk); #1; brk_active = 1'b1; brk_clr_en = 1'b0;
    wreg(4'b0100); tick(3);
    phase = "R10";
    @(negedge clk); #1; brk_clr_en = 1'b1;
    wreg(4'b0100); tick(2);
    @(negedge clk); #1; brk_active = 1'b0; brk_clr_en = 1'b0;
    tick(4);
    phase = "R11";
    set_pin(1'b1); tick(3); set_pin(1'b0); tick(5);
    @(negedge clk); #1; brk_active = 1'b1;
    fetch(); tick(3);
    @(negedge clk); #1; brk_active = 1'b0;

    phase = "R7";
    set_pin(1'b1); tick(3);
    wreg(4'b0011); set_pin(1'b0); tick(5);
    @(negedge clk); #1; rst_n = 1'b0;
    tick(3);
    @(negedge clk); #1; rst_n = 1'b1;
    tick(6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule